// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast reference clock into a slow core clock whose average frequency sits between two integer divide results. It divides by a first ratio for a programmed number of output periods, then by a second ratio for another programmed number of periods, and repeats. With a 24 MHz reference, a first ratio of 733 held for 8 periods and a second ratio of 732 held for 11 periods give an average near 32.768 kHz.

All configuration fields are stored as the wanted value minus one. A bypass path hands the reference clock straight to the output. An input gate starts and stops the counters. An output gate forces the output low. A one-cycle strobe marks the first reference cycle of every output period.

Reconfiguration is done with both gates off. Load the ratios and repeat counts, select dual mode, clear bypass, then open both gates.

Top module: `dualmod_clkdiv`

## Requirements
- R1: Every ratio and repeat field encodes its value minus one: a stored field F means F+1 reference cycles (ratio) or F+1 output periods (repeat count).
- R2: With dual mode off, every output period lasts `div_a`+1 reference cycles. The output is high for the first floor(N/2) cycles of a period of length N and low for the rest.
- R3: With dual mode on, the block produces `rep_a`+1 periods of length `div_a`+1, then `rep_b`+1 periods of length `div_b`+1, and repeats this pattern. Each run of the divider starts with the first ratio.
- R4: A period length of 1 (ratio field 0) passes the reference clock to `clk_out` while the divider runs.
- R5: With `bypass_en` high and `gate_out_en` high, `clk_out` equals `clk`, whatever the ratio, repeat, dual or input-gate settings are.
- R6: With `gate_out_en` low, `clk_out` stays low. The counters and `edge_stb` keep running if the input gate is on.
- R7: With `gate_in_en` low, the counters return to the start state. `edge_stb` is low, and `clk_out` is low unless bypassed. When the gate reopens, a fresh pattern starts: `edge_stb` is high in the first cycle, and the first period uses the first ratio.
- R8: A change of any ratio, repeat or mode field takes effect only at the next period boundary. The period in progress keeps its length and its high time.
- R9: `edge_stb` is high for exactly one reference cycle, the first cycle of each output period. Consecutive strobes are N cycles apart.
- R10: `active` is high when either gate enable is high.
- R11: While `rst_n` is low, and in the first cycle after it rises, `clk_out` and `edge_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_in_en | input | 1 | Input gate: counters run while high |
| gate_out_en | input | 1 | Output gate: output forced low while low |
| bypass_en | input | 1 | Route the reference clock to the output |
| dual_en | input | 1 | Alternate between the two ratios |
| div_a | input | CNT_W | First ratio minus one |
| div_b | input | CNT_W | Second ratio minus one |
| rep_a | input | REP_W | Periods at the first ratio minus one |
| rep_b | input | REP_W | Periods at the second ratio minus one |
| clk_out | output | 1 | Divided (or bypassed) clock |
| edge_stb | output | 1 | One-cycle mark of each period start |
| active | output | 1 | Either gate enabled |

## Verification
The bench sweeps every pairing of small ratios and repeat counts in both modes. This catches an off-by-one in the field encoding, which would lengthen or shorten every period by one cycle or repeat a ratio once too often or too seldom. It also catches an odd-length period with the wrong high time, which would show up as a shifted falling edge.

A ratio change in the middle of a period catches a design that reloads at once and truncates the current period. Closing the input gate while the second ratio is active catches a design that resumes the old pattern instead of restarting with the first ratio.

Ratio 1, bypass, and the output gate are probed in both clock phases. This exposes an output that is stuck, or one that leaks through while gated. One full run at the 24 MHz setting confirms the total cycle count of the 19-period pattern.

// File: rtl/dmd_pkg.sv
// Shared types for the dual-modulus divider.
// Assumes: nothing beyond IEEE 1800-2017.
package dmd_pkg;
    // Which of the two programmed ratios the current period uses
    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } ratio_sel_e;
endpackage

// File: rtl/dmd_period_counter.sv
// Counts reference cycles inside one output period and derives the
// output level and the period-boundary flag.
// Assumes: cur_div is the period length minus one and is held stable
// by the sequencer for the whole period.
module dmd_period_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cur_div,
    output logic             wrap,
    output logic             first,
    output logic             lvl_high
);
    localparam int HW = CNT_W + 1;

    logic [CNT_W-1:0] ph_cnt;
    logic [HW-1:0]    half;

    // Position inside the current period; cleared when idle or at wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_cnt <= '0;
        end else if (wrap) begin
            ph_cnt <= '0;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    // Boundary, start and level decode of the period position
    always_comb begin
        half     = ({1'b0, cur_div} + HW'(1)) >> 1;
        wrap     = run && (ph_cnt == cur_div);
        first    = (ph_cnt == '0);
        lvl_high = ({1'b0, ph_cnt} < half);
    end
endmodule

// File: rtl/dmd_ratio_sequencer.sv
// Chooses the ratio for each output period: counts periods at the
// active ratio and swaps ratio after the programmed repeat count.
// Assumes: wrap marks the last cycle of a period; configuration is
// sampled only at wrap, or continuously while the divider is idle.
module dmd_ratio_sequencer
    import dmd_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wrap,
    input  logic             dual_en,
    input  logic [CNT_W-1:0] div_a,
    input  logic [CNT_W-1:0] div_b,
    input  logic [REP_W-1:0] rep_a,
    input  logic [REP_W-1:0] rep_b,
    output ratio_sel_e       sel,
    output logic [CNT_W-1:0] cur_div
);
    logic [REP_W-1:0] rep_cnt;
    logic [REP_W-1:0] rep_lim;
    logic             last_rep;

    // Repeat limit of the ratio now in use
    always_comb begin
        rep_lim  = (sel == SEL_A) ? rep_a : rep_b;
        last_rep = (rep_cnt == rep_lim);
    end

    // Ratio selection, repeat count and latched ratio, updated per period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sel     <= SEL_A;
            rep_cnt <= '0;
            cur_div <= div_a;
        end else if (wrap) begin
            if (!dual_en) begin
                sel     <= SEL_A;
                rep_cnt <= '0;
                cur_div <= div_a;
            end else if (last_rep) begin
                sel     <= (sel == SEL_A) ? SEL_B : SEL_A;
                rep_cnt <= '0;
                cur_div <= (sel == SEL_A) ? div_b : div_a;
            end else begin
                rep_cnt <= rep_cnt + 1'b1;
                cur_div <= (sel == SEL_A) ? div_a : div_b;
            end
        end
    end
endmodule

// File: rtl/dmd_output_stage.sv
// Forms the output clock from the divider level, the ratio-1 pass
// path and the bypass path, then applies the output gate.
// Assumes: clk is the reference clock, used here as data for the
// pass-through paths; run already includes the input gate.
module dmd_output_stage (
    input  logic clk,
    input  logic rdy,
    input  logic run,
    input  logic gate_out_en,
    input  logic bypass_en,
    input  logic div_is_one,
    input  logic lvl_high,
    input  logic first,
    output logic clk_out,
    output logic edge_stb
);
    logic div_lvl;

    // Output selection and gating
    always_comb begin
        div_lvl  = run && (div_is_one ? clk : lvl_high);
        clk_out  = rdy && gate_out_en && (bypass_en ? clk : div_lvl);
        edge_stb = run && first;
    end
endmodule

// File: rtl/dualmod_clkdiv.sv
// Dual-modulus fractional clock divider top. Divides the reference
// clock by one ratio for a number of periods, then by a second ratio,
// with bypass and separate input and output gates.
// Assumes: synchronous active-low reset; fields hold value minus one.
module dualmod_clkdiv
    import dmd_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_in_en,
    input  logic             gate_out_en,
    input  logic             bypass_en,
    input  logic             dual_en,
    input  logic [CNT_W-1:0] div_a,
    input  logic [CNT_W-1:0] div_b,
    input  logic [REP_W-1:0] rep_a,
    input  logic [REP_W-1:0] rep_b,
    output logic             clk_out,
    output logic             edge_stb,
    output logic             active
);
    logic             rdy;
    logic             run;
    logic             wrap;
    logic             first;
    logic             lvl_high;
    logic [CNT_W-1:0] cur_div;
    ratio_sel_e       sel;

    // Ready flag: outputs stay quiet for one cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0;
        end else begin
            rdy <= 1'b1;
        end
    end

    // Run qualifier and enable status
    always_comb begin
        run    = rdy && gate_in_en;
        active = gate_in_en || gate_out_en;
    end

    dmd_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cur_div  (cur_div),
        .wrap     (wrap),
        .first    (first),
        .lvl_high (lvl_high)
    );

    dmd_ratio_sequencer #(.CNT_W(CNT_W), .REP_W(REP_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .wrap    (wrap),
        .dual_en (dual_en),
        .div_a   (div_a),
        .div_b   (div_b),
        .rep_a   (rep_a),
        .rep_b   (rep_b),
        .sel     (sel),
        .cur_div (cur_div)
    );

    dmd_output_stage u_out (
        .clk         (clk),
        .rdy         (rdy),
        .run         (run),
        .gate_out_en (gate_out_en),
        .bypass_en   (bypass_en),
        .div_is_one  (cur_div == '0),
        .lvl_high    (lvl_high),
        .first       (first),
        .clk_out     (clk_out),
        .edge_stb    (edge_stb)
    );
endmodule

// File: rtl/dmd_clkdiv_chk.sv
// Assertion checker for dualmod_clkdiv, attached by bind.
// Assumes: sampled at the reference clock rising edge.
module dmd_clkdiv_chk
    import dmd_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_in_en,
    input logic             gate_out_en,
    input logic             bypass_en,
    input logic             dual_en,
    input logic             clk_out,
    input logic             edge_stb,
    input logic             active,
    input logic             rdy,
    input logic             run,
    input logic             wrap,
    input ratio_sel_e       sel,
    input logic [CNT_W-1:0] cur_div
);
    // R6: a closed output gate silences the output
    assert_gate_out_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_out_en |-> !clk_out);

    // R7: a closed input gate stops strobes and, unless bypassed, the output
    assert_gate_in_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_in_en |-> (!edge_stb && (bypass_en || !clk_out)));

    // R7: reopening the input gate starts a fresh period at once
    assert_restart_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && $past(rdy) && gate_in_en && !$past(gate_in_en)) |-> edge_stb);

    // R9: for periods longer than one cycle the strobe lasts one cycle
    assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && cur_div != '0) |=> !edge_stb);

    // R3: ratio selection changes only at a boundary or on idle
    assert_sel_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |-> ($past(wrap) || !$past(run)));

    // R2: single mode never leaves the first ratio after a boundary
    assert_single_stays_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap && !dual_en) |-> (sel == SEL_A));

    // R10: enable status follows the two gates
    assert_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        active == (gate_in_en || gate_out_en));
endmodule

bind dualmod_clkdiv dmd_clkdiv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_in_en  (gate_in_en),
    .gate_out_en (gate_out_en),
    .bypass_en   (bypass_en),
    .dual_en     (dual_en),
    .clk_out     (clk_out),
    .edge_stb    (edge_stb),
    .active      (active),
    .rdy         (rdy),
    .run         (run),
    .wrap        (wrap),
    .sel         (sel),
    .cur_div     (cur_div)
);

// File: tb/test_dualmod_clkdiv.sv
module test_dualmod_clkdiv;
    localparam int CNT_W = 10;
    localparam int REP_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gate_in_en = 1'b0;
    logic             gate_out_en = 1'b0;
    logic             bypass_en = 1'b0;
    logic             dual_en = 1'b0;
    logic [CNT_W-1:0] div_a = '0;
    logic [CNT_W-1:0] div_b = '0;
    logic [REP_W-1:0] rep_a = '0;
    logic [REP_W-1:0] rep_b = '0;
    logic             clk_out;
    logic             edge_stb;
    logic             active;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    dualmod_clkdiv #(.CNT_W(CNT_W), .REP_W(REP_W)) i_dualmod_clkdiv (
        .clk(clk), .rst_n(rst_n), .gate_in_en(gate_in_en),
        .gate_out_en(gate_out_en), .bypass_en(bypass_en), .dual_en(dual_en),
        .div_a(div_a), .div_b(div_b), .rep_a(rep_a), .rep_b(rep_b),
        .clk_out(clk_out), .edge_stb(edge_stb), .active(active)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    // Gates off, load configuration, then open both gates (drive after posedge)
    task automatic start_cfg(input int na, input int nb, input int ma, input int mb,
                             input bit dual, input bit gout);
        @(posedge clk); #2;
        gate_in_en = 1'b0; gate_out_en = 1'b0;
        @(posedge clk); #2;
        div_a = CNT_W'(na); div_b = CNT_W'(nb);
        rep_a = REP_W'(ma); rep_b = REP_W'(mb);
        dual_en = dual; bypass_en = 1'b0;
        @(posedge clk); #2;
        gate_in_en = 1'b1; gate_out_en = gout;
    endtask

    // Observe one period of length n at negedges; one check per period
    task automatic check_period(input int n, input bit gout, input string req);
        int bad = 0;
        int first_c = -1;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (edge_stb !== (c == 0) ||
                clk_out !== (gout && n > 1 && c < n / 2)) begin
                bad++;
                if (first_c < 0) first_c = c;
            end
        end
        check(bad == 0, req, $sformatf("period len %0d, first bad cycle", n),
              first_c, -1);
    endtask

    function automatic int exp_len(input int na, input int nb, input int ma,
                                   input int mb, input bit dual, input int p);
        int pos;
        if (!dual) return na + 1;
        pos = p % (ma + mb + 2);
        return (pos <= ma) ? na + 1 : nb + 1;
    endfunction

    initial begin
        #1_900_000;
        check(1'b0, "WATCHDOG", "run did not end", 0, 1);
        finish_run();
    end

    initial begin
        // R11: reset state with everything enabled
        gate_in_en = 1'b1; gate_out_en = 1'b1; bypass_en = 1'b1; div_a = 3;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            check(clk_out === 1'b0 && edge_stb === 1'b0, "R11", "outputs in reset",
                  {clk_out, edge_stb}, 0);
        end
        bypass_en = 1'b0;
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        check(clk_out === 1'b0 && edge_stb === 1'b0, "R11", "first cycle after reset",
              {clk_out, edge_stb}, 0);

        // R10: active for all gate combinations
        for (int g = 0; g < 4; g++) begin
            gate_in_en = g[0]; gate_out_en = g[1]; #1;
            check(active === (g != 0), "R10", "active", active, g != 0);
        end

        // R1, R2: single mode sweep of ratio fields
        for (int na = 0; na < 10; na++) begin
            start_cfg(na, 0, 0, 0, 1'b0, 1'b1);
            for (int p = 0; p < 4; p++) check_period(na + 1, 1'b1, "R2");
        end

        // R1, R3: dual mode sweep of ratios and repeat counts
        for (int na = 0; na < 5; na++)
            for (int nb = 0; nb < 5; nb++)
                for (int ma = 0; ma < 3; ma++)
                    for (int mb = 0; mb < 3; mb++) begin
                        start_cfg(na, nb, ma, mb, 1'b1, 1'b1);
                        for (int p = 0; p < 2 * (ma + mb + 2); p++)
                            check_period(exp_len(na, nb, ma, mb, 1'b1, p), 1'b1, "R3");
                    end

        // R4: ratio 1 passes the reference clock
        start_cfg(0, 0, 0, 0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check(clk_out === 1'b1 && edge_stb === 1'b1, "R4", "high phase pass",
                  {clk_out, edge_stb}, 3);
            @(negedge clk); #1;
            check(clk_out === 1'b0, "R4", "low phase pass", clk_out, 0);
        end

        // R8: ratio change mid-period applies at the next boundary
        start_cfg(5, 0, 0, 0, 1'b0, 1'b1);
        begin
            int bad = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (edge_stb !== (c == 0) || clk_out !== (c < 3)) bad++;
                if (c == 2) begin #1; div_a = 2; end
            end
            check(bad == 0, "R8", "period in progress kept", bad, 0);
        end
        check_period(3, 1'b1, "R8");
        check_period(3, 1'b1, "R8");

        // R7: closing the input gate in the second-ratio phase restarts the pattern
        start_cfg(2, 4, 1, 1, 1'b1, 1'b1);
        check_period(3, 1'b1, "R7");
        check_period(3, 1'b1, "R7");
        check_period(5, 1'b1, "R7");
        @(posedge clk); #2; gate_in_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(edge_stb === 1'b0 && clk_out === 1'b0, "R7", "frozen outputs",
                  {clk_out, edge_stb}, 0);
        end
        @(posedge clk); #2; gate_in_en = 1'b1;
        for (int p = 0; p < 5; p++)
            check_period(exp_len(2, 4, 1, 1, 1'b1, p), 1'b1, "R7");

        // R6: closed output gate silences clk_out, strobes continue (R9)
        start_cfg(3, 0, 0, 0, 1'b0, 1'b0);
        for (int p = 0; p < 3; p++) check_period(4, 1'b0, "R6");
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check(clk_out === 1'b0, "R6", "high phase gated", clk_out, 0);
        end

        // R5: bypass follows clk regardless of settings and input gate
        start_cfg(7, 3, 2, 1, 1'b1, 1'b1);
        @(posedge clk); #2; bypass_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (i == 3) gate_in_en = 1'b0;
            @(posedge clk); #1;
            check(clk_out === 1'b1, "R5", "bypass high", clk_out, 1);
            @(negedge clk); #1;
            check(clk_out === 1'b0, "R5", "bypass low", clk_out, 0);
        end
        gate_out_en = 1'b0;
        @(posedge clk); #1;
        check(clk_out === 1'b0, "R6", "bypass gated", clk_out, 0);

        // R3: target 32.768 kHz setting, whole pattern cycle count
        start_cfg(732, 731, 7, 10, 1'b1, 1'b1);
        begin
            int total = 0;
            for (int p = 0; p < 38; p++) begin
                check_period(exp_len(732, 731, 7, 10, 1'b1, p), 1'b1, "R3");
                if (p < 19) total += exp_len(732, 731, 7, 10, 1'b1, p);
            end
            check(total == 13916, "R3", "cycles per pattern", total, 13916);
        end

        finish_run();
    end
endmodule